// File: doc/BRIEF.md
# Delay-Slot Next-PC Unit

This block advances the program counter of a 32-bit pipelined processor whose control transfers have one delay slot. It holds three addresses: the instruction now executing, the one after it, and the one after that. Each accepted cycle brings a decoded transfer class, a link request, the immediate and jump-target fields of the instruction, an already evaluated condition bit and a register operand. From these the block computes the next address triple.

When a transfer is taken, the instruction that follows the transfer (the delay slot) still becomes current. The new target takes effect one instruction later. A branch-likely whose condition fails skips the slot instruction and raises an annul pulse. A link request records the address just past the slot. A register jump also reports the two low bits of its target, so that a neighbouring block can raise an alignment fault.

Fetch, condition evaluation, register file access and exception handling are done elsewhere. All outputs are registered. An input is accepted only in a cycle where `in_valid` is high and `stall` is low.

Top module: `npc_sequencer`

## Requirements
- R1: During synchronous active-low reset the triple loads `RESET_VEC`, `RESET_VEC+4` and `RESET_VEC+8`, and `link_we`, `annul_slot`, `link_data` and `reg_tgt_lsb` load zero.
- R2: `xfer_kind` codes are 0 none, 1 branch, 2 branch-likely, 3 direct jump and 4 register jump; codes 5 to 7 act as none. An accepted none, or an accepted branch with `cond_true` low, moves the triple one step: current takes next, next takes next-next, and next-next grows by 4.
- R3: A taken branch (code 1 or 2 with `cond_true` high) makes the old next PC current. Its target is the old current PC plus 4 plus the 16-bit offset shifted left by 2 and sign-extended from bit 17. The target becomes next, and target+4 becomes next-next.
- R4: A direct jump (code 3) makes the old next PC current. Its target is bits 31..28 of the old current PC joined with the 26-bit field and two zero bits. The target becomes next, and target+4 becomes next-next.
- R5: A register jump (code 4) uses all 32 bits of `reg_operand` as its target and places it like R4. After any accepted cycle, `reg_tgt_lsb` shows `reg_operand[1:0]` if that cycle was a register jump and 0 otherwise. Between accepted cycles it holds its value.
- R6: An accepted transfer (codes 1 to 4) with `link_req` high drives `link_we` high for exactly the following cycle, whether or not a branch is taken. In that cycle `link_data` shows the next-next PC as it was before the update. `link_req` with code 0 has no effect, and `link_data` holds between writes.
- R7: An accepted branch-likely with `cond_true` low loads the triple with old next-next, old next-next+4 and old next-next+8, and drives `annul_slot` high for exactly the following cycle.
- R8: A cycle with `stall` high leaves the triple, `link_data` and `reg_tgt_lsb` unchanged, and `link_we` and `annul_slot` are low after it.
- R9: A cycle with `in_valid` low behaves like a stalled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present this cycle |
| stall | input | 1 | Freeze the unit this cycle |
| xfer_kind | input | 3 | Transfer class code (see R2) |
| link_req | input | 1 | Transfer writes its return address |
| imm16 | input | 16 | Branch offset field, in words |
| jfield | input | 26 | Direct jump target field, in words |
| cond_true | input | 1 | Branch condition result |
| reg_operand | input | 32 | Register value for register jumps |
| pc_cur | output | 32 | Address of the executing instruction |
| pc_nxt | output | 32 | Next address |
| pc_nn | output | 32 | Address after next |
| link_we | output | 1 | Return-address write pulse |
| link_data | output | 32 | Return address |
| annul_slot | output | 1 | Slot instruction was skipped |
| reg_tgt_lsb | output | 2 | Low bits of last register-jump target |

## Verification
The bench aims at offsets with bit 15 set (including the most negative, 0x8000), where a design that extends from the wrong bit would send the branch forward instead of backward. It tests a direct jump from an address with nonzero top bits; a design that drops the region bits would jump to a low address. It tests branch-likely with both outcomes, where a design that mixes up annul and taken would either run the skipped slot or lose the target. It also tests link with untaken branches and under stall; a design that links only on taken branches, or that writes while stalled, would corrupt the return register.

// File: rtl/npc_pkg.sv
// Package: shared encodings for the next-PC unit.
// Assumes the decoder delivers the transfer class as a 3-bit code.
package npc_pkg;

    typedef enum logic [2:0] {
        XFER_NONE = 3'd0,
        XFER_BR   = 3'd1,
        XFER_BRL  = 3'd2,
        XFER_JDIR = 3'd3,
        XFER_JREG = 3'd4
    } xfer_e;

    // True for classes that redirect the flow and may link.
    function automatic logic is_transfer(input xfer_e k);
        return (k == XFER_BR) || (k == XFER_BRL) || (k == XFER_JDIR) || (k == XFER_JREG);
    endfunction

endpackage

// File: rtl/npc_target_calc.sv
// Module: computes the three candidate targets from the current PC and the
// instruction fields. Purely combinational.
// Assumes XLEN > JT_W + 2 and XLEN > OFF_W + 2.
module npc_target_calc #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned OFF_W      = 16,
    parameter int unsigned JT_W       = 26,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [JT_W-1:0]  jfield,
    input  logic [XLEN-1:0]  reg_op,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jdir_tgt,
    output logic [XLEN-1:0]  jreg_tgt
);
    localparam int unsigned DISP_W = OFF_W + 2;
    localparam int unsigned EXT_W  = XLEN - DISP_W;
    localparam int unsigned HI_W   = XLEN - JT_W - 2;
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] disp;

    // Word offset to byte displacement, sign taken from the top offset bit.
    always_comb disp = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};

    // Branch target relative to the address after the branch.
    always_comb br_tgt = cur_pc + STEP + disp;

    // Direct jump stays inside the current address region.
    always_comb jdir_tgt = {cur_pc[XLEN-1 -: HI_W], jfield, 2'b00};

    // Register jump takes the operand unchanged.
    always_comb jreg_tgt = reg_op;

endmodule

// File: rtl/npc_next_select.sv
// Module: chooses the next PC triple and the side-band pulses for one
// accepted instruction. Purely combinational; holds everything when go is low.
// Assumes targets from npc_target_calc and a decoded class code.
module npc_next_select
    import npc_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic            go,
    input  logic [2:0]      kind,
    input  logic            link_req,
    input  logic            cond_true,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] nxt_pc,
    input  logic [XLEN-1:0] nn_pc,
    input  logic [XLEN-1:0] br_tgt,
    input  logic [XLEN-1:0] jdir_tgt,
    input  logic [XLEN-1:0] jreg_tgt,
    output logic [XLEN-1:0] n_cur,
    output logic [XLEN-1:0] n_nxt,
    output logic [XLEN-1:0] n_nn,
    output logic            link_fire,
    output logic            annul_fire,
    output logic [1:0]      n_lsb
);
    localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

    xfer_e k;

    // Map the raw code onto the class enum; unknown codes act as none.
    always_comb begin
        case (kind)
            3'd1:    k = XFER_BR;
            3'd2:    k = XFER_BRL;
            3'd3:    k = XFER_JDIR;
            3'd4:    k = XFER_JREG;
            default: k = XFER_NONE;
        endcase
    end

    // Pick the next triple: sequential step, redirect after slot, or skip.
    always_comb begin
        n_cur      = cur_pc;
        n_nxt      = nxt_pc;
        n_nn       = nn_pc;
        link_fire  = 1'b0;
        annul_fire = 1'b0;
        n_lsb      = 2'b00;
        if (go) begin
            n_cur     = nxt_pc;
            n_nxt     = nn_pc;
            n_nn      = nn_pc + STEP;
            link_fire = link_req && is_transfer(k);
            case (k)
                XFER_BR: begin
                    if (cond_true) begin
                        n_nxt = br_tgt;
                        n_nn  = br_tgt + STEP;
                    end
                end
                XFER_BRL: begin
                    if (cond_true) begin
                        n_nxt = br_tgt;
                        n_nn  = br_tgt + STEP;
                    end else begin
                        n_cur      = nn_pc;
                        n_nxt      = nn_pc + STEP;
                        n_nn       = nn_pc + STEP2;
                        annul_fire = 1'b1;
                    end
                end
                XFER_JDIR: begin
                    n_nxt = jdir_tgt;
                    n_nn  = jdir_tgt + STEP;
                end
                XFER_JREG: begin
                    n_nxt = jreg_tgt;
                    n_nn  = jreg_tgt + STEP;
                    n_lsb = jreg_tgt[1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/npc_sequencer.sv
// Module: top of the delay-slot next-PC unit. Holds the registered PC
// triple and the side-band outputs; accepts one instruction per cycle
// when in_valid is high and stall is low.
// Assumes a synchronous active-low reset and a 4-byte instruction size.
module npc_sequencer #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned OFF_W      = 16,
    parameter int unsigned JT_W       = 26,
    parameter int unsigned INSN_BYTES = 4,
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              stall,
    input  logic [2:0]        xfer_kind,
    input  logic              link_req,
    input  logic [OFF_W-1:0]  imm16,
    input  logic [JT_W-1:0]   jfield,
    input  logic              cond_true,
    input  logic [XLEN-1:0]   reg_operand,
    output logic [XLEN-1:0]   pc_cur,
    output logic [XLEN-1:0]   pc_nxt,
    output logic [XLEN-1:0]   pc_nn,
    output logic              link_we,
    output logic [XLEN-1:0]   link_data,
    output logic              annul_slot,
    output logic [1:0]        reg_tgt_lsb
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] RV   = XLEN'(RESET_VEC);

    logic            go;
    logic [XLEN-1:0] br_tgt, jdir_tgt, jreg_tgt;
    logic [XLEN-1:0] n_cur, n_nxt, n_nn;
    logic            link_fire, annul_fire;
    logic [1:0]      n_lsb;

    // Accept the instruction only when presented and not frozen.
    always_comb go = in_valid && !stall;

    npc_target_calc #(
        .XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W), .INSN_BYTES(INSN_BYTES)
    ) u_tgt (
        .cur_pc   (pc_cur),
        .offset   (imm16),
        .jfield   (jfield),
        .reg_op   (reg_operand),
        .br_tgt   (br_tgt),
        .jdir_tgt (jdir_tgt),
        .jreg_tgt (jreg_tgt)
    );

    npc_next_select #(
        .XLEN(XLEN), .INSN_BYTES(INSN_BYTES)
    ) u_sel (
        .go         (go),
        .kind       (xfer_kind),
        .link_req   (link_req),
        .cond_true  (cond_true),
        .cur_pc     (pc_cur),
        .nxt_pc     (pc_nxt),
        .nn_pc      (pc_nn),
        .br_tgt     (br_tgt),
        .jdir_tgt   (jdir_tgt),
        .jreg_tgt   (jreg_tgt),
        .n_cur      (n_cur),
        .n_nxt      (n_nxt),
        .n_nn       (n_nn),
        .link_fire  (link_fire),
        .annul_fire (annul_fire),
        .n_lsb      (n_lsb)
    );

    // PC triple register: reset vector sequence, else the selected triple.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_cur <= RV;
            pc_nxt <= RV + STEP;
            pc_nn  <= RV + STEP + STEP;
        end else begin
            pc_cur <= n_cur;
            pc_nxt <= n_nxt;
            pc_nn  <= n_nn;
        end
    end

    // One-cycle pulses for link write and slot annul.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_we    <= 1'b0;
            annul_slot <= 1'b0;
        end else begin
            link_we    <= link_fire;
            annul_slot <= annul_fire;
        end
    end

    // Return address capture and alignment bits, held between updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_data   <= '0;
            reg_tgt_lsb <= 2'b00;
        end else begin
            if (link_fire) link_data <= pc_nn;
            if (go)        reg_tgt_lsb <= n_lsb;
        end
    end

    // ---------------- assertions ----------------
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!link_we && !annul_slot)); // R1

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (xfer_kind == 3'd0 || (xfer_kind == 3'd1 && !cond_true)))
        |=> (pc_nn == $past(pc_nn) + STEP)); // R2

    AST_SLOT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (xfer_kind == 3'd1 || xfer_kind == 3'd3 || xfer_kind == 3'd4 ||
                (xfer_kind == 3'd2 && cond_true)))
        |=> (pc_cur == $past(pc_nxt))); // R3

    AST_LINK_PAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == $past(pc_nn))); // R6

    AST_ANNUL_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        annul_slot |-> (pc_cur == $past(pc_nn))); // R7

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(pc_cur) && $stable(pc_nxt) && $stable(pc_nn) &&
                 !link_we && !annul_slot)); // R8

endmodule

// File: tb/tb_npc_sequencer.sv
`timescale 1ns/1ps
module tb_npc_sequencer;
    localparam logic [31:0] RV = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, stall = 1'b0, link_req = 1'b0, cond_true = 1'b0;
    logic [2:0]  xfer_kind = 3'd0;
    logic [15:0] imm16 = '0;
    logic [25:0] jfield = '0;
    logic [31:0] reg_operand = '0;
    logic [31:0] pc_cur, pc_nxt, pc_nn, link_data;
    logic        link_we, annul_slot;
    logic [1:0]  reg_tgt_lsb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [31:0] e_cur, e_nxt, e_nn, e_data;
    logic        e_we, e_ann;
    logic [1:0]  e_lsb;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;

    npc_sequencer #(.RESET_VEC(RV)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stall(stall),
        .xfer_kind(xfer_kind), .link_req(link_req), .imm16(imm16),
        .jfield(jfield), .cond_true(cond_true), .reg_operand(reg_operand),
        .pc_cur(pc_cur), .pc_nxt(pc_nxt), .pc_nn(pc_nn), .link_we(link_we),
        .link_data(link_data), .annul_slot(annul_slot), .reg_tgt_lsb(reg_tgt_lsb)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "pc_cur", pc_cur, e_cur);
        chk(tag, "pc_nxt", pc_nxt, e_nxt);
        chk(tag, "pc_nn", pc_nn, e_nn);
        chk(tag, "link_we", 32'(link_we), 32'(e_we));
        chk(tag, "link_data", link_data, e_data);
        chk(tag, "annul_slot", 32'(annul_slot), 32'(e_ann));
        chk(tag, "reg_tgt_lsb", 32'(reg_tgt_lsb), 32'(e_lsb));
    endtask

    // Drive one cycle at the falling edge, update the model, compare after the edge.
    task automatic step(input string tag, input bit v, input bit st, input int kind,
                        input bit lk, input logic [15:0] imm, input logic [25:0] jt,
                        input bit cnd, input logic [31:0] rop);
        logic [31:0] tgt;
        bit accepted, xfer, taken;
        in_valid = v; stall = st; xfer_kind = 3'(kind); link_req = lk;
        imm16 = imm; jfield = jt; cond_true = cnd; reg_operand = rop;
        accepted = v && !st;
        xfer = (kind >= 1 && kind <= 4);
        e_we = 0; e_ann = 0;
        if (accepted) begin
            if (lk && xfer) begin e_we = 1; e_data = e_nn; end
            e_lsb = (kind == 4) ? rop[1:0] : 2'b00;
            taken = (kind == 3 || kind == 4 || ((kind == 1 || kind == 2) && cnd));
            if (kind == 3)      tgt = (e_cur & 32'hF000_0000) | ({6'b0, jt} * 4);
            else if (kind == 4) tgt = rop;
            else                tgt = e_cur + 4 + 32'(int'($signed(imm)) * 4);
            if (taken) begin
                e_cur = e_nxt; e_nxt = tgt; e_nn = tgt + 4;
            end else if (kind == 2) begin
                e_cur = e_nn; e_nxt = e_nn + 4; e_nn = e_nn + 8; e_ann = 1;
            end else begin
                e_cur = e_nxt; e_nxt = e_nn; e_nn = e_nn + 4;
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        e_cur = RV; e_nxt = RV + 4; e_nn = RV + 8; e_data = 0;
        e_we = 0; e_ann = 0; e_lsb = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        // R2: sequential and untaken ordinary branch, unknown codes, link on none ignored
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 1, 0, 16'h0010, 0, 0, 0);
        step("R2", 1, 0, 6, 1, 0, 0, 1, 0);
        step("R6", 1, 0, 0, 1, 0, 0, 1, 0);
        // R3: taken branches, positive, -1 word, most negative
        step("R3", 1, 0, 1, 0, 16'h0020, 0, 1, 0);
        step("R3", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 0, 1, 0, 16'hFFFF, 0, 1, 0);
        step("R3", 1, 0, 1, 0, 16'h8000, 0, 1, 0);
        step("R3", 1, 0, 2, 0, 16'h7FFF, 0, 1, 0);
        // R7: likely not taken, with link
        step("R7", 1, 0, 2, 0, 16'h0040, 0, 0, 0);
        step("R7", 1, 0, 2, 1, 16'h0040, 0, 0, 0);
        // R4: direct jump from region with nonzero top bits
        step("R4", 1, 0, 3, 0, 0, 26'h3FF_FFFF, 0, 0);
        step("R4", 1, 0, 3, 1, 0, 26'h012_3456, 0, 0);
        // R5: register jump, unaligned operand, then lsb clears
        step("R5", 1, 0, 4, 0, 0, 0, 0, 32'h8000_1237);
        step("R5", 1, 0, 4, 1, 0, 0, 0, 32'h0000_4002);
        step("R5", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 0, 0, 0, 0);
        // R6: link on untaken branch
        step("R6", 1, 0, 1, 1, 16'h0100, 0, 0, 0);
        // R8: stall with a linking taken jump
        step("R8", 1, 1, 4, 1, 0, 0, 0, 32'h1111_2223);
        step("R8", 1, 1, 2, 0, 0, 0, 0, 0);
        // R9: invalid cycles
        step("R9", 0, 0, 3, 1, 0, 26'h000_0ABC, 0, 0);
        step("R9", 0, 0, 2, 1, 0, 0, 0, 0);
        // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            b = lfsr;
            step("R2", a[0] | a[1], a[2] & a[3], int'(a[6:4]), a[7], b[15:0], b[31:6],
                 a[8], {a[31:12], b[11:0]});
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule